// File: doc/BRIEF.md
# Serial Clock Phase Corrector

This block watches a serial bit clock made by an off-chip PLL and compares it with the frame reference of the parallel port. It samples that clock with a fast system clock. Each time a frame arrives it measures, in system-clock ticks, how far the nearest rising edge sits from the frame tick. When the offset is larger than a tolerance (about 100 ns, turned into ticks from the system clock rate), it snaps its own regenerated serial clock back into line with the frame. It also sets a sticky interrupt that warns of possible data corruption.

The block also drives the serial frame pulse, which is slaved to the frame reference. A mode input selects a 4.096 MHz or an 8.192 MHz external clock. At 8.192 MHz the regenerated clock output is held low, because the external clock feeds the bus directly, and the frame pulse is timed by the external clock edge. In a multi-device setup one device is the master and drives the frame pulse. The others are slaves: they turn the frame pin into an input and take their timing from the master's pulse. Slave operation is refused when the parallel port runs at its lowest rate.

The phase machine has three states. PH_IDLE waits for a frame. The frame moves it to PH_HUNT, which counts ticks since the frame. A detected rising edge, or the count reaching the period plus the synchronizer depth, moves it to PH_JUDGE. PH_JUDGE decides on a correction for one tick and returns to PH_IDLE.

Top module: `serclk_phase_corrector`

## Requirements
- R1: While reset is held and right after it, `phase_irq` is 0, `frame_out` is 0 and `frame_oe` is 1.
- R2: The measured offset is `n - f`. Here `f` is the tick at which the active frame input is sampled high, and `n` is the first tick at or after `f-1` at which `ext_clk` is sampled 1 after being 0. If the offset exceeds P/2, it is folded to `n - f - P`. P is 30 ticks when `sel_8m`=0 and 15 ticks when `sel_8m`=1. The two-stage synchronizer delay is removed from the measurement.
- R3: An offset whose magnitude is at most TOL = TOL_NS*SYS_MHZ/1000 ticks (12 by default) changes neither `ser_clk_out` nor `phase_irq`.
- R4: An offset whose magnitude exceeds TOL sets `phase_irq` at tick `n+3`. The flag stays set until it is cleared.
- R5: `phase_irq` clears on the tick after a tick in which `irq_clr` is sampled 1. A new violation wins over a clear in the same tick.
- R6: After a correction for a frame at tick `f`, with `sel_8m`=0, `ser_clk_out` seen after tick `t` equals 1 exactly when `(t-f) mod 30 < 15`. It keeps this phase until the next correction.
- R7: If no rising edge is detected within P+2 ticks of the frame, the block corrects as in R6 and sets `phase_irq` at tick `f+P+4`.
- R8: In master mode with `sel_8m`=0, `frame_out` is 1 for exactly the one tick following the frame tick `f`.
- R9: With `sel_8m`=1, `ser_clk_out` stays 0. In master mode, `frame_out` is 1 for one tick after tick `n+2`, which places the pulse on the external clock edge.
- R10: With `slave_req`=1 (and `rate_low`=0), `frame_oe` and `frame_out` are 0. Timing comes from `frame_in`, and pulses on `ref_frame` have no effect.
- R11: With `rate_low`=1, `slave_req` has no effect: `frame_oe` stays 1, `frame_in` is ignored and `ref_frame` is the timing source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | Serial clock from the external PLL, asynchronous |
| ref_frame | input | 1 | Parallel-port frame reference, one-tick pulse |
| frame_in | input | 1 | Frame pulse received from the master device |
| sel_8m | input | 1 | 1 selects an 8.192 MHz external clock, 0 selects 4.096 MHz |
| slave_req | input | 1 | 1 requests slave frame timing |
| rate_low | input | 1 | 1 when the parallel port runs at its lowest rate; blocks slave operation |
| irq_clr | input | 1 | Write-one-to-clear strobe for the interrupt |
| ser_clk_out | output | 1 | Regenerated, phase-corrected serial clock |
| frame_out | output | 1 | Serial frame pulse driven in master mode |
| frame_oe | output | 1 | Output enable of the frame pin |
| phase_irq | output | 1 | Sticky flag for a phase excursion or a lost clock |

## Verification
The hard cases sit at the edges of the measurement. The first is an edge at the far end of the window, where the raw offset must fold to a negative value. The second is an edge one tick before the frame, which the synchronizer only reports once the frame has already been taken. The third is a clock that never arrives. The stimulus schedules every frame tick ahead of time and shifts the external clock so that its rising edge lands a chosen number of ticks from that frame: exactly on the ±12 boundaries, one tick past them, and at -1. For the lost-clock case it stops the external clock entirely. The expected regenerated clock is then predicted tick by tick from the last correcting frame.

// File: rtl/scp_pkg.sv
package scp_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_HUNT  = 2'd1,
        PH_JUDGE = 2'd2
    } ph_state_t;

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
            last_q  <= chain_q[STAGES-1];
        end
    end

    // rise_o is seen STAGES ticks after the tick that first samples the input high
    assign rise_o = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/scp_phase_fsm.sv
module scp_phase_fsm
    import scp_pkg::*;
#(
    parameter int CW        = 7,
    parameter int TOL_TICKS = 12,
    parameter int COMP      = 1,
    parameter int TAIL      = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_i,
    input  logic          rise_i,
    input  logic [CW-1:0] period_i,
    output logic          fix_o,
    output logic [CW-1:0] load_o
);

    ph_state_t state_q, state_d;

    logic [CW-1:0]        cnt_q;
    logic signed [CW:0]   err_q;
    logic                 miss_q;
    logic [CW-1:0]        limit;
    logic signed [CW:0]   e_raw, e_fold, e_mag, half_s, per_s;
    logic [CW-1:0]        cnt_inc;

    assign limit  = period_i + CW'(TAIL);
    assign per_s  = $signed({1'b0, period_i});
    assign half_s = $signed({2'b00, period_i[CW-1:1]});
    assign e_raw  = $signed({1'b0, cnt_q}) - $signed((CW+1)'(COMP));

    always_comb begin
        e_fold = (e_raw > half_s) ? (e_raw - per_s) : e_raw;
        e_mag  = err_q[CW] ? -err_q : err_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:  if (frame_i) state_d = PH_HUNT;
            PH_HUNT:  if (rise_i || cnt_q == limit) state_d = PH_JUDGE;
            PH_JUDGE: state_d = PH_IDLE;
            default:  state_d = PH_IDLE;
        endcase
    end

    // tick counter and captured offset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            err_q  <= '0;
            miss_q <= 1'b0;
        end else begin
            if (state_q == PH_IDLE) begin
                if (frame_i) begin
                    cnt_q  <= '0;
                    miss_q <= 1'b0;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (state_q == PH_HUNT) begin
                if (rise_i) begin
                    err_q  <= e_fold;
                    miss_q <= 1'b0;
                end else if (cnt_q == limit) begin
                    miss_q <= 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        cnt_inc = cnt_q + 1'b1;
        load_o  = (cnt_inc >= period_i) ? (cnt_inc - period_i) : cnt_inc;
        fix_o   = (state_q == PH_JUDGE) &&
                  (miss_q || (e_mag > $signed((CW+1)'(TOL_TICKS))));
    end

    AST_HUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_HUNT) |-> (cnt_q <= limit)) else $error("hunt overran"); // R7

endmodule

// File: rtl/scp_divider.sv
module scp_divider #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] period_i,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          en_i,
    output logic          clk_o
);

    logic [CW-1:0] dcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            dcnt_q <= '0;
        else if (load_i)                       dcnt_q <= load_val_i;
        else if (dcnt_q >= period_i - CW'(1))  dcnt_q <= '0;
        else                                   dcnt_q <= dcnt_q + 1'b1;
    end

    assign clk_o = en_i && (dcnt_q < (period_i >> 1));

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> (dcnt_q < period_i)) else $error("divider out of range"); // R6

endmodule

// File: rtl/scp_frame_ctl.sv
module scp_frame_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_frame_i,
    input  logic frame_in_i,
    input  logic slave_req_i,
    input  logic rate_low_i,
    input  logic mode_8m_i,
    input  logic rise_i,
    input  logic fix_i,
    input  logic irq_clr_i,
    output logic ref_eff_o,
    output logic frame_o,
    output logic frame_oe_o,
    output logic irq_o
);

    logic slave_eff;
    logic pend_q, frame_q, irq_q;

    assign slave_eff  = slave_req_i & ~rate_low_i;
    assign ref_eff_o  = slave_eff ? frame_in_i : ref_frame_i;
    assign frame_oe_o = ~slave_eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            frame_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            if (ref_eff_o)   pend_q <= 1'b1;
            else if (rise_i) pend_q <= 1'b0;
            frame_q <= ~slave_eff & (mode_8m_i ? (pend_q & rise_i) : ref_frame_i);
            if (fix_i)          irq_q <= 1'b1;
            else if (irq_clr_i) irq_q <= 1'b0;
        end
    end

    assign frame_o = frame_q;
    assign irq_o   = irq_q;

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(fix_i)) else $error("irq without fix"); // R4
    AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_q |=> !frame_q) else $error("frame pulse too long"); // R8

endmodule

// File: rtl/serclk_phase_corrector.sv
module serclk_phase_corrector #(
    parameter int SYS_MHZ          = 125,
    parameter int TOL_NS           = 100,
    parameter int PERIOD_4M_TICKS  = 30,
    parameter int PERIOD_8M_TICKS  = 15,
    parameter int SYNC_STAGES      = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    input  logic ref_frame,
    input  logic frame_in,
    input  logic sel_8m,
    input  logic slave_req,
    input  logic rate_low,
    input  logic irq_clr,
    output logic ser_clk_out,
    output logic frame_out,
    output logic frame_oe,
    output logic phase_irq
);

    localparam int TOL_TICKS = TOL_NS * SYS_MHZ / 1000;
    localparam int CW        = $clog2(PERIOD_4M_TICKS + SYNC_STAGES + 4) + 1;
    localparam logic [CW-1:0] P4 = CW'(PERIOD_4M_TICKS);
    localparam logic [CW-1:0] P8 = CW'(PERIOD_8M_TICKS);

    logic          rise, ref_eff, fix;
    logic [CW-1:0] period, load_val;

    assign period = sel_8m ? P8 : P4;

    scp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(ext_clk), .rise_o(rise)
    );

    scp_phase_fsm #(
        .CW(CW), .TOL_TICKS(TOL_TICKS), .COMP(SYNC_STAGES - 1), .TAIL(SYNC_STAGES)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .frame_i(ref_eff), .rise_i(rise),
        .period_i(period), .fix_o(fix), .load_o(load_val)
    );

    scp_divider #(.CW(CW)) u_div (
        .clk(clk), .rst_n(rst_n), .period_i(period), .load_i(fix),
        .load_val_i(load_val), .en_i(~sel_8m), .clk_o(ser_clk_out)
    );

    scp_frame_ctl u_frm (
        .clk(clk), .rst_n(rst_n), .ref_frame_i(ref_frame), .frame_in_i(frame_in),
        .slave_req_i(slave_req), .rate_low_i(rate_low), .mode_8m_i(sel_8m),
        .rise_i(rise), .fix_i(fix), .irq_clr_i(irq_clr), .ref_eff_o(ref_eff),
        .frame_o(frame_out), .frame_oe_o(frame_oe), .irq_o(phase_irq)
    );

endmodule

// File: tb/serclk_phase_corrector_tb.sv
module serclk_phase_corrector_tb;

    localparam int P4 = 30, P8 = 15, TOL = 12;

    logic clk = 1'b0, rst_n = 1'b0, ext_clk = 1'b0, ref_frame = 1'b0, frame_in = 1'b0;
    logic sel_8m = 1'b0, slave_req = 1'b0, rate_low = 1'b0, irq_clr = 1'b0;
    logic ser_clk_out, frame_out, frame_oe, phase_irq;

    serclk_phase_corrector u_dut (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .ref_frame(ref_frame),
        .frame_in(frame_in), .sel_8m(sel_8m), .slave_req(slave_req),
        .rate_low(rate_low), .irq_clr(irq_clr), .ser_clk_out(ser_clk_out),
        .frame_out(frame_out), .frame_oe(frame_oe), .phase_irq(phase_irq)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int per();
        return sel_8m ? P8 : P4;
    endfunction

    function automatic int md(int a, int p);
        return ((a % p) + p) % p;
    endfunction

    int ext_off = 0;
    bit ext_run = 1'b1;
    // value chosen here is sampled at tick cyc+1; rising edges fall on ticks == ext_off mod P
    always @(negedge clk) ext_clk <= ext_run && (md(cyc + 1 - ext_off, per()) < per() / 2);

    typedef struct {
        int    when;
        int    sig;
        bit    val;
        string tag;
    } exp_t;
    exp_t sb[$];
    int n_chk = 0, n_bad = 0;
    int align_f = 0;
    bit irq_m = 1'b0;

    task automatic push(int when, int sig, bit val, string tag);
        exp_t x;
        x.when = when; x.sig = sig; x.val = val; x.tag = tag;
        sb.push_back(x);
    endtask

    function automatic bit read_sig(int s);
        case (s)
            0:       return phase_irq;
            1:       return ser_clk_out;
            2:       return frame_out;
            default: return frame_oe;
        endcase
    endfunction

    // monitor: compare every due expectation at the falling edge
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].when == cyc) begin
                n_chk++;
                if (read_sig(sb[i].sig) !== sb[i].val) begin
                    n_bad++;
                    $display("FAIL %s tick %0d sig %0d actual %0b expected %0b",
                             sb[i].tag, cyc, sb[i].sig, read_sig(sb[i].sig), sb[i].val);
                end
                sb.delete(i);
            end
        end
    end

    task automatic wait_until(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic push_window(int f, int p, string tag);
        for (int t = f + p + 6; t <= f + 3 * p + 6; t++)
            push(t, 1, sel_8m ? 1'b0 : (md(t - align_f, p) < p / 2), sel_8m ? "R9" : tag);
    endtask

    task automatic shot(int e, bit via_in);
        int p, f, n, ew;
        bit slave_eff, eff, viol;
        string tag;
        @(negedge clk);
        p = per();
        f = cyc + 40;
        ext_off = f + e;
        slave_eff = slave_req && !rate_low;
        eff = (via_in == slave_eff);
        n = (e >= -1) ? f + e : f + e + p;
        ew = n - f;
        if (ew > p / 2) ew -= p;
        viol = eff && (ew > TOL || ew < -TOL);
        tag = !eff ? (slave_req && rate_low ? "R11" : "R10") : (viol ? "R6" : "R3");
        if (slave_eff) begin
            push(f, 2, 1'b0, "R10");
            push(f, 3, 1'b0, "R10");
        end else begin
            push(f, 3, 1'b1, slave_req ? "R11" : "R1");
            if (!eff) push(f, 2, 1'b0, "R11");
            else if (!sel_8m) begin
                push(f, 2, 1'b1, "R8");
                push(f + 1, 2, 1'b0, "R8");
            end else begin
                push(n + 1, 2, 1'b0, "R9");
                push(n + 2, 2, 1'b1, "R9");
                push(n + 3, 2, 1'b0, "R9");
            end
        end
        if (viol && !irq_m) begin
            push(n + 2, 0, 1'b0, "R4");
            push(n + 3, 0, 1'b1, "R4");
        end
        if (viol) begin
            irq_m = 1'b1;
            align_f = f;
        end
        push_window(f, p, tag);
        push(f + 3 * p + 7, 0, irq_m, eff ? (viol ? "R4" : "R3") : tag);
        wait_until(f - 1);
        if (via_in) frame_in = 1'b1; else ref_frame = 1'b1;
        @(negedge clk);
        frame_in = 1'b0;
        ref_frame = 1'b0;
        wait_until(f + 3 * p + 9);
    endtask

    task automatic lost();
        int p, f;
        ext_run = 1'b0;
        repeat (4) @(negedge clk);
        p = per();
        f = cyc + 20;
        if (!irq_m) push(f + p + 3, 0, 1'b0, "R7");
        push(f + p + 4, 0, 1'b1, "R7");
        irq_m = 1'b1;
        align_f = f;
        push_window(f, p, "R7");
        wait_until(f - 1);
        ref_frame = 1'b1;
        @(negedge clk);
        ref_frame = 1'b0;
        wait_until(f + 3 * p + 9);
        ext_run = 1'b1;
        repeat (2 * p) @(negedge clk);
    endtask

    task automatic clear_irq();
        @(negedge clk);
        irq_clr = 1'b1;
        push(cyc + 1, 0, 1'b0, "R5");
        @(negedge clk);
        irq_clr = 1'b0;
        irq_m = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        // R1: reset state, during and after reset
        push(2, 0, 1'b0, "R1"); push(2, 2, 1'b0, "R1"); push(2, 3, 1'b1, "R1");
        push(7, 0, 1'b0, "R1"); push(7, 2, 1'b0, "R1"); push(7, 3, 1'b1, "R1");
        wait_until(4);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        shot(14, 1'b0);      // R2 R4 R6: beyond tolerance, aligns the clock
        clear_irq();         // R5
        shot(12, 1'b0);      // R3 boundary inside
        shot(-12, 1'b0);     // R2 fold, R3 boundary inside
        shot(-13, 1'b0);     // R2 fold, just outside
        clear_irq();
        shot(13, 1'b0);      // just outside, positive side
        clear_irq();
        shot(-1, 1'b0);      // edge one tick before the frame
        lost();              // R7
        clear_irq();

        slave_req = 1'b1;    // R10
        repeat (3) @(negedge clk);
        shot(14, 1'b0);      // ref_frame ignored
        shot(14, 1'b1);      // frame_in drives timing
        clear_irq();

        rate_low = 1'b1;     // R11
        repeat (3) @(negedge clk);
        shot(14, 1'b1);      // frame_in ignored
        shot(13, 1'b0);      // ref_frame used
        clear_irq();
        rate_low = 1'b0;
        slave_req = 1'b0;

        sel_8m = 1'b1;       // R9
        repeat (50) @(negedge clk);
        shot(3, 1'b0);
        shot(-5, 1'b0);
        lost();              // R7 in the faster mode

        repeat (5) @(negedge clk);
        if (sb.size() != 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 pending expectations actual %0d expected 0", sb.size());
        end
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual running expected done");
        finish_run();
    end

endmodule